// File: doc/BRIEF.md
# Split TLB Insert and Purge Controller

This block keeps the translation entries of a small split translation buffer and carries out the maintenance commands that change them. There are two streams, instruction and data. Each stream has an eight-entry translation cache, filled in rotation, and four pinned translation registers, chosen by a slot number carried in the command. Each entry holds a valid bit, a virtual base address and a page size. A command gives an opcode, a stream bit, a base, a page size, a slot, and a tag that says whether a global purge started here or came from another processor.

Every command is compared against every entry of both streams. The block removes overlapped entries and, for inserts, writes the new entry. When the command overlaps a pinned register in a way that is not allowed, the block sets a sticky machine-check pending flag. This flag is reported as a one-cycle abort pulse no later than the next serialize strobe. How the block treats each overlap depends on four things: the opcode, whether the overlapped entry is on the same stream or the opposite one, whether it is a cache entry or a pinned register, and whether a global purge was started locally or arrived from a remote processor.

A command is accepted in a cycle when `cmd_valid` is high and `busy` is low. The block is busy for one cycle. In the cycle after that it pulses `done`, together with the number of entries that overlap removed and a flag that says whether a new entry was written.

Top module: `tlb_maint_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `mc_abort` are low and every entry of both streams is invalid. A serialize strobe right after reset therefore gives no abort, and a first insert removes nothing.
- R2: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` is then high for exactly one cycle and `done` pulses in the next cycle. `cmd_valid` is ignored while `busy` is high. Opcodes 6 and 7 complete with no effect on any entry.
- R3: An insert is opcode 0 for a cache insert and opcode 1 for a pinned-register insert. The stream bit is 0 for instruction and 1 for data. An insert removes every overlapped cache entry in both streams, counts those entries in `done_removed`, writes the new entry and sets `done_written`.
- R4: An insert that overlaps a valid pinned register of its own stream writes nothing and sets the machine-check pending flag. It still removes the overlapped cache entries.
- R5: An insert that overlaps only opposite-stream pinned registers is written. Those registers are kept and no machine check is raised.
- R6: A local cache purge (opcode 2) and a locally started global purge (opcode 3 with `cmd_remote` = 0) remove the overlapped cache entries of both streams. If either one overlaps any pinned register, it sets the pending flag and keeps that register.
- R7: A global purge that arrives from a remote processor (opcode 3 with `cmd_remote` = 1) removes the overlapped cache entries of both streams. It leaves every pinned register in place and never raises a machine check.
- R8: The purge-entire command (opcode 4) removes every valid cache entry of both streams whatever its address. It keeps the pinned registers and raises no machine check.
- R9: A pinned-register purge (opcode 5) removes the overlapped pinned registers of its own stream and the overlapped cache entries of both streams. It keeps opposite-stream pinned registers and never raises a machine check.
- R10: The pending flag holds until a serialize strobe. The cycle after the serialize edge, `mc_abort` pulses once if the flag was set or if a violating command completed on that same edge. The flag is then clear, and a serialize strobe with nothing pending gives no pulse.
- R11: The cache of each stream is filled in rotation over its 8 entries. The ninth insert into a stream replaces the oldest entry, and that replacement is not counted in `done_removed`.
- R12: A pinned-register insert writes the slot named by `cmd_slot`. A non-overlapping earlier entry in that slot is replaced without being counted as removed.
- R13: `cmd_pgsz` holds the base-2 logarithm of the page size, from 12 to 28. Two ranges overlap when each base is below the other base plus its page size, so ranges that only touch at an edge do not overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode (0 cache insert, 1 register insert, 2 local purge, 3 global purge, 4 purge entire, 5 register purge) |
| cmd_dside | input | 1 | Stream: 0 instruction, 1 data |
| cmd_base | input | VA_W | Virtual base, aligned to the page size |
| cmd_pgsz | input | PS_W | Log2 of the page size |
| cmd_slot | input | SLOT_W | Pinned-register slot for a register insert |
| cmd_remote | input | 1 | Global purge came from a remote processor |
| serialize | input | 1 | Serialization strobe |
| busy | output | 1 | Command in execution |
| done | output | 1 | Command finished (one cycle) |
| done_written | output | 1 | A new entry was written (valid with done) |
| done_removed | output | CNT_W | Entries removed by overlap (valid with done) |
| mc_abort | output | 1 | Machine-check abort pulse |

## Verification
The assertions assume that `cmd_pgsz` stays between 12 and 28 and that every base is aligned to its page size. Under those two conditions a newly written entry always overlaps itself, and an overlap test can never wrap past the top of the address space. The stimulus builds each base by masking the low bits below the chosen page size, and it picks page sizes only from a fixed list in that range. The assertions also assume that `cmd_remote` matters only for opcode 3, and the stimulus varies it freely on the other opcodes.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;

  typedef enum logic [2:0] {
    OP_TC_INS    = 3'd0,
    OP_TR_INS    = 3'd1,
    OP_PURGE_LOC = 3'd2,
    OP_PURGE_GLB = 3'd3,
    OP_PURGE_ALL = 3'd4,
    OP_TR_PURGE  = 3'd5,
    OP_RSVD6     = 3'd6,
    OP_RSVD7     = 3'd7
  } maint_op_e;

  // Index 0 is the instruction stream, index 1 the data stream.
  typedef struct packed {
    logic [1:0] tc_purge;
    logic [1:0] tr_purge;
    logic [1:0] tc_wr;
    logic [1:0] tr_wr;
    logic       tc_flush;
    logic       viol;
  } maint_act_t;

endpackage

// File: rtl/tlb_range_cmp.sv
module tlb_range_cmp #(
  parameter int VA_W = 32,
  parameter int PS_W = 5
) (
  input  logic [VA_W-1:0] a_base,
  input  logic [PS_W-1:0] a_ps,
  input  logic [VA_W-1:0] b_base,
  input  logic [PS_W-1:0] b_ps,
  output logic            overlap
);

  localparam logic [VA_W:0] ONE = {{VA_W{1'b0}}, 1'b1};

  logic [VA_W:0] a_end;
  logic [VA_W:0] b_end;

  // One extra bit keeps a range that ends at the top of the space from wrapping.
  always_comb begin
    a_end   = {1'b0, a_base} + (ONE << a_ps);
    b_end   = {1'b0, b_base} + (ONE << b_ps);
    overlap = ({1'b0, a_base} < b_end) && ({1'b0, b_base} < a_end);
  end

endmodule

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank #(
  parameter int  N      = 8,
  parameter int  VA_W   = 32,
  parameter int  PS_W   = 5,
  parameter bit  USE_RR = 1'b1,
  localparam int SLOT_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W  = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   q_base,
  input  logic [PS_W-1:0]   q_ps,
  input  logic              purge_i,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  output logic              any_hit_o,
  output logic [CNT_W-1:0]  removed_o
);

  logic [N-1:0]      vld_q, vld_d;
  logic [VA_W-1:0]   base_q [N];
  logic [VA_W-1:0]   base_d [N];
  logic [PS_W-1:0]   ps_q   [N];
  logic [PS_W-1:0]   ps_d   [N];
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [SLOT_W-1:0] slot;
  logic [N-1:0]      ovl;
  logic [N-1:0]      hit;
  logic [N-1:0]      drop;

  for (genvar k = 0; k < N; k++) begin : g_cmp
    tlb_range_cmp #(.VA_W(VA_W), .PS_W(PS_W)) u_cmp (
      .a_base  (base_q[k]),
      .a_ps    (ps_q[k]),
      .b_base  (q_base),
      .b_ps    (q_ps),
      .overlap (ovl[k])
    );
  end

  assign hit       = vld_q & ovl;
  assign any_hit_o = |hit;

  always_comb begin
    slot = USE_RR ? ptr_q : wr_slot_i;
    if (flush_i)      drop = vld_q;
    else if (purge_i) drop = hit;
    else              drop = '0;

    removed_o = '0;
    for (int k = 0; k < N; k++) removed_o = removed_o + CNT_W'(drop[k]);

    vld_d  = vld_q & ~drop;
    base_d = base_q;
    ps_d   = ps_q;
    ptr_d  = ptr_q;
    if (wr_i) begin
      vld_d[slot]  = 1'b1;
      base_d[slot] = q_base;
      ps_d[slot]   = q_ps;
      if (USE_RR) ptr_d = (ptr_q == SLOT_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int k = 0; k < N; k++) begin
        base_q[k] <= '0;
        ps_q[k]   <= '0;
      end
    end else begin
      vld_q  <= vld_d;
      ptr_q  <= ptr_d;
      base_q <= base_d;
      ps_q   <= ps_d;
    end
  end

endmodule

// File: rtl/tlb_maint_policy.sv
module tlb_maint_policy
  import tlb_maint_pkg::*;
(
  input  maint_op_e  op,
  input  logic       dside,
  input  logic       remote,
  input  logic [1:0] tr_hit,
  output maint_act_t act
);

  logic tr_same;
  logic tr_any;

  always_comb begin
    tr_same = tr_hit[dside];
    tr_any  = |tr_hit;
    act     = '0;
    unique case (op)
      OP_TC_INS, OP_TR_INS: begin
        // Opposite-stream cache entries are always purged; a same-stream
        // register overlap blocks the write and flags a machine check.
        act.tc_purge = 2'b11;
        act.viol     = tr_same;
        if (!tr_same) begin
          if (op == OP_TC_INS) act.tc_wr[dside] = 1'b1;
          else                 act.tr_wr[dside] = 1'b1;
        end
      end
      OP_PURGE_LOC: begin
        act.tc_purge = 2'b11;
        act.viol     = tr_any;
      end
      OP_PURGE_GLB: begin
        act.tc_purge = 2'b11;
        act.viol     = !remote && tr_any;
      end
      OP_PURGE_ALL: begin
        act.tc_flush = 1'b1;
      end
      OP_TR_PURGE: begin
        act.tc_purge        = 2'b11;
        act.tr_purge[dside] = 1'b1;
      end
      default: begin
        act = '0;
      end
    endcase
  end

endmodule

// File: rtl/tlb_maint_ctrl.sv
module tlb_maint_ctrl
  import tlb_maint_pkg::*;
#(
  parameter int  VA_W   = 32,
  parameter int  PS_W   = 5,
  parameter int  TC_N   = 8,
  parameter int  TR_N   = 4,
  localparam int SLOT_W = (TR_N > 1) ? $clog2(TR_N) : 1,
  localparam int CNT_W  = $clog2(2 * TC_N + 2 * TR_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_dside,
  input  logic [VA_W-1:0]   cmd_base,
  input  logic [PS_W-1:0]   cmd_pgsz,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic              cmd_remote,
  input  logic              serialize,
  output logic              busy,
  output logic              done,
  output logic              done_written,
  output logic [CNT_W-1:0]  done_removed,
  output logic              mc_abort
);

  localparam int TC_SW = (TC_N > 1) ? $clog2(TC_N) : 1;
  localparam int TC_CW = $clog2(TC_N + 1);
  localparam int TR_CW = $clog2(TR_N + 1);

  // Command latch
  logic              busy_q, busy_d;
  maint_op_e         op_q;
  logic              dside_q;
  logic [VA_W-1:0]   base_q;
  logic [PS_W-1:0]   ps_q;
  logic [SLOT_W-1:0] slot_q;
  logic              remote_q;

  // Result and machine-check state
  logic             done_q, done_d;
  logic             wrote_q, wrote_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             pend_q, pend_d;
  logic             abort_q, abort_d;

  logic             accept;
  logic             exec;
  maint_act_t       act;
  logic [1:0]       tc_any;
  logic [1:0]       tr_any;
  logic [TC_CW-1:0] tc_rem [2];
  logic [TR_CW-1:0] tr_rem [2];
  logic [CNT_W-1:0] rem_sum;
  logic             commit_viol;

  assign accept = cmd_valid && !busy_q;
  assign exec   = busy_q;

  for (genvar s = 0; s < 2; s++) begin : g_side
    tlb_entry_bank #(
      .N(TC_N), .VA_W(VA_W), .PS_W(PS_W), .USE_RR(1'b1)
    ) u_tc (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_base    (base_q),
      .q_ps      (ps_q),
      .purge_i   (exec && act.tc_purge[s]),
      .flush_i   (exec && act.tc_flush),
      .wr_i      (exec && act.tc_wr[s]),
      .wr_slot_i ({TC_SW{1'b0}}),
      .any_hit_o (tc_any[s]),
      .removed_o (tc_rem[s])
    );

    tlb_entry_bank #(
      .N(TR_N), .VA_W(VA_W), .PS_W(PS_W), .USE_RR(1'b0)
    ) u_tr (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_base    (base_q),
      .q_ps      (ps_q),
      .purge_i   (exec && act.tr_purge[s]),
      .flush_i   (1'b0),
      .wr_i      (exec && act.tr_wr[s]),
      .wr_slot_i (slot_q),
      .any_hit_o (tr_any[s]),
      .removed_o (tr_rem[s])
    );
  end

  tlb_maint_policy u_policy (
    .op     (op_q),
    .dside  (dside_q),
    .remote (remote_q),
    .tr_hit (tr_any),
    .act    (act)
  );

  always_comb begin
    rem_sum     = CNT_W'(tc_rem[0]) + CNT_W'(tc_rem[1])
                + CNT_W'(tr_rem[0]) + CNT_W'(tr_rem[1]);
    commit_viol = exec && act.viol;

    busy_d  = accept;
    done_d  = exec;
    wrote_d = exec && ((|act.tc_wr) || (|act.tr_wr));
    rem_d   = exec ? rem_sum : '0;

    if (serialize) begin
      abort_d = pend_q || commit_viol;
      pend_d  = 1'b0;
    end else begin
      abort_d = 1'b0;
      pend_d  = pend_q || commit_viol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wrote_q <= 1'b0;
      rem_q   <= '0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      wrote_q <= wrote_d;
      rem_q   <= rem_d;
      pend_q  <= pend_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_RSVD7;
      dside_q  <= 1'b0;
      base_q   <= '0;
      ps_q     <= '0;
      slot_q   <= '0;
      remote_q <= 1'b0;
    end else if (accept) begin
      op_q     <= maint_op_e'(cmd_op);
      dside_q  <= cmd_dside;
      base_q   <= cmd_base;
      ps_q     <= cmd_pgsz;
      slot_q   <= cmd_slot;
      remote_q <= cmd_remote;
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign done_written = wrote_q;
  assign done_removed = rem_q;
  assign mc_abort     = abort_q;

endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       serialize,
  input logic       busy,
  input logic       done,
  input logic       mc_abort,
  input logic [2:0] op_q,
  input logic       dside_q,
  input logic       remote_q,
  input logic       pend_q,
  input logic [1:0] tc_any,
  input logic [1:0] tr_any
);

  p_busy_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy |=> busy);

  p_insert_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == 3'd0 && !tr_any[dside_q] |=> tc_any[dside_q]);

  p_local_purge_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == 3'd2 |=> tc_any == 2'b00);

  p_remote_keeps_tr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == 3'd3 && remote_q |=> $stable(tr_any));

  p_remote_no_mc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == 3'd3 && remote_q && !serialize |=> pend_q == $past(pend_q));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == 3'd4 |=> tc_any == 2'b00);

  p_trp_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == 3'd5 |=> !tr_any[dside_q]);

  p_trp_opp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == 3'd5 |=> tr_any[!dside_q] == $past(tr_any[!dside_q]));

  p_abort_needs_ser_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mc_abort |-> $past(serialize));

  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mc_abort |-> !pend_q);

  p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !serialize |=> pend_q);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind tlb_maint_ctrl tlb_maint_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .serialize (serialize),
  .busy      (busy),
  .done      (done),
  .mc_abort  (mc_abort),
  .op_q      (op_q),
  .dside_q   (dside_q),
  .remote_q  (remote_q),
  .pend_q    (pend_q),
  .tc_any    (tc_any),
  .tr_any    (tr_any)
);

// File: tb/tlb_maint_ctrl_test.sv
module tlb_maint_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam logic [31:0] GHOST = 32'h7F00_0000;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic        cmd_dside;
  logic [31:0] cmd_base;
  logic [4:0]  cmd_pgsz;
  logic [1:0]  cmd_slot;
  logic        cmd_remote;
  logic        serialize;
  logic        busy;
  logic        done;
  logic        done_written;
  logic [4:0]  done_removed;
  logic        mc_abort;

  int checks;
  int fails;

  // Reference state
  bit          m_tc_v [2][8];
  logic [31:0] m_tc_b [2][8];
  int          m_tc_p [2][8];
  int          m_rr   [2];
  bit          m_tr_v [2][4];
  logic [31:0] m_tr_b [2][4];
  int          m_tr_p [2][4];
  bit          m_pend;

  tlb_maint_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_dside    (cmd_dside),
    .cmd_base     (cmd_base),
    .cmd_pgsz     (cmd_pgsz),
    .cmd_slot     (cmd_slot),
    .cmd_remote   (cmd_remote),
    .serialize    (serialize),
    .busy         (busy),
    .done         (done),
    .done_written (done_written),
    .done_removed (done_removed),
    .mc_abort     (mc_abort)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit ovl(logic [31:0] b1, int p1, logic [31:0] b2, int p2);
    longint e1;
    longint e2;
    e1 = longint'(b1) + (longint'(1) << p1);
    e2 = longint'(b2) + (longint'(1) << p2);
    return (longint'(b1) < e2) && (longint'(b2) < e1);
  endfunction

  task automatic model_purge_tc(input logic [31:0] b, input int p, inout int cnt);
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 8; k++)
        if (m_tc_v[s][k] && ovl(m_tc_b[s][k], m_tc_p[s][k], b, p)) begin
          m_tc_v[s][k] = 1'b0;
          cnt++;
        end
  endtask

  task automatic run_cmd(input int op, input int d, input logic [31:0] base, input int ps,
                         input int slot, input bit rem, input bit ser, input bit ghost,
                         input string tag);
    int exp_rem;
    bit exp_wr;
    bit viol;
    bit tr_same;
    bit tr_any;
    bit exp_ab;
    exp_rem = 0; exp_wr = 0; viol = 0; tr_same = 0; tr_any = 0;
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++)
        if (m_tr_v[s][k] && ovl(m_tr_b[s][k], m_tr_p[s][k], base, ps)) begin
          tr_any = 1;
          if (s == d) tr_same = 1;
        end
    case (op)
      0, 1: begin
        model_purge_tc(base, ps, exp_rem);
        viol = tr_same;
        if (!viol) begin
          exp_wr = 1;
          if (op == 0) begin
            m_tc_v[d][m_rr[d]] = 1; m_tc_b[d][m_rr[d]] = base; m_tc_p[d][m_rr[d]] = ps;
            m_rr[d] = (m_rr[d] + 1) % 8;
          end else begin
            m_tr_v[d][slot] = 1; m_tr_b[d][slot] = base; m_tr_p[d][slot] = ps;
          end
        end
      end
      2: begin model_purge_tc(base, ps, exp_rem); viol = tr_any; end
      3: begin model_purge_tc(base, ps, exp_rem); viol = !rem && tr_any; end
      4: begin
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 8; k++)
            if (m_tc_v[s][k]) begin m_tc_v[s][k] = 0; exp_rem++; end
      end
      5: begin
        model_purge_tc(base, ps, exp_rem);
        for (int k = 0; k < 4; k++)
          if (m_tr_v[d][k] && ovl(m_tr_b[d][k], m_tr_p[d][k], base, ps)) begin
            m_tr_v[d][k] = 0; exp_rem++;
          end
      end
      default: ;
    endcase
    if (ser) begin
      exp_ab = m_pend || viol;
      m_pend = 0;
    end else begin
      exp_ab = 0;
      m_pend = m_pend || viol;
    end

    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = op[2:0];
    cmd_dside  = d[0];
    cmd_base   = base;
    cmd_pgsz   = ps[4:0];
    cmd_slot   = slot[1:0];
    cmd_remote = rem;
    @(negedge clk);
    check(busy == 1'b1, {tag, " R2 busy"}, busy, 1);
    check(done == 1'b0, {tag, " R2 done early"}, done, 0);
    if (ghost) begin
      cmd_op    = 3'd0;
      cmd_base  = GHOST;
      cmd_dside = 1'b0;
      cmd_pgsz  = 5'd12;
    end else begin
      cmd_valid = 1'b0;
    end
    serialize = ser;
    @(negedge clk);
    cmd_valid = 1'b0;
    serialize = 1'b0;
    check(done == 1'b1, {tag, " R2 done"}, done, 1);
    check(busy == 1'b0, {tag, " R2 busy end"}, busy, 0);
    check(int'(done_removed) == exp_rem, {tag, " removed"}, done_removed, exp_rem);
    check(done_written == exp_wr, {tag, " written"}, done_written, exp_wr);
    check(mc_abort == exp_ab, {tag, " R10 abort"}, mc_abort, exp_ab);
  endtask

  task automatic do_serialize(input string tag);
    bit exp_ab;
    exp_ab = m_pend;
    m_pend = 0;
    @(negedge clk);
    serialize = 1'b1;
    @(negedge clk);
    serialize = 1'b0;
    check(mc_abort == exp_ab, {tag, " R10 abort pulse"}, mc_abort, exp_ab);
    @(negedge clk);
    check(mc_abort == 1'b0, {tag, " R10 abort single"}, mc_abort, 0);
  endtask

  function automatic string op_tag(int op, bit rem);
    case (op)
      0, 1: return "R3";
      2: return "R6";
      3: return rem ? "R7" : "R6";
      4: return "R8";
      5: return "R9";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    checks = 0;
    fails  = 0;
    for (int s = 0; s < 2; s++) begin
      m_rr[s] = 0;
      for (int k = 0; k < 8; k++) begin m_tc_v[s][k] = 0; m_tc_b[s][k] = '0; m_tc_p[s][k] = 12; end
      for (int k = 0; k < 4; k++) begin m_tr_v[s][k] = 0; m_tr_b[s][k] = '0; m_tr_p[s][k] = 12; end
    end
    m_pend     = 0;
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_op     = 3'd0;
    cmd_dside  = 1'b0;
    cmd_base   = '0;
    cmd_pgsz   = 5'd12;
    cmd_slot   = 2'd0;
    cmd_remote = 1'b0;
    serialize  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(mc_abort == 1'b0, "R1 abort", mc_abort, 0);
    do_serialize("R1");

    // R13 adjacent pages do not overlap; R3 opposite-stream cache purge
    run_cmd(0, 0, 32'h0000_1000, 12, 0, 0, 0, 0, "R1 R13 first insert");
    run_cmd(0, 0, 32'h0000_2000, 12, 0, 0, 0, 0, "R13 adjacent");
    run_cmd(0, 1, 32'h0000_0000, 16, 0, 0, 0, 0, "R3 cross-stream purge");

    // R5 opposite-stream register overlap
    run_cmd(1, 0, 32'h0010_0000, 20, 0, 0, 0, 0, "R12 register insert");
    run_cmd(0, 1, 32'h0010_8000, 12, 0, 0, 0, 0, "R5 opposite register");
    do_serialize("R5");

    // R4 same-stream register overlap
    run_cmd(0, 0, 32'h0010_4000, 12, 0, 0, 0, 0, "R4 same register");
    do_serialize("R4");
    do_serialize("R10 nothing pending");

    // R6 local purge hitting a register
    run_cmd(2, 0, 32'h0000_0000, 24, 0, 0, 0, 0, "R6 local purge");
    do_serialize("R6");
    run_cmd(5, 0, 32'h0010_0000, 20, 0, 0, 0, 0, "R6 register kept");

    // R7 remote global purge, then local global purge
    run_cmd(1, 1, 32'h2000_0000, 16, 1, 0, 0, 0, "R7 setup register");
    run_cmd(0, 0, 32'h2800_0000, 12, 0, 0, 0, 0, "R7 setup cache");
    run_cmd(3, 0, 32'h2000_0000, 28, 0, 1, 0, 0, "R7 remote purge");
    do_serialize("R7");
    run_cmd(3, 0, 32'h2000_0000, 28, 0, 0, 0, 0, "R6 local global purge");
    do_serialize("R6 global");

    // R8 purge entire
    run_cmd(0, 0, 32'h0100_0000, 12, 0, 0, 0, 0, "R8 setup");
    run_cmd(0, 1, 32'h0200_0000, 12, 0, 0, 0, 0, "R8 setup");
    run_cmd(0, 1, 32'h0300_0000, 12, 0, 0, 0, 0, "R8 setup");
    run_cmd(4, 0, 32'h0000_0000, 12, 0, 0, 0, 0, "R8 purge entire");
    do_serialize("R8");
    run_cmd(5, 1, 32'h2000_0000, 16, 0, 0, 0, 0, "R8 register survived");

    // R9 register purge keeps opposite stream
    run_cmd(1, 0, 32'h3000_0000, 16, 2, 0, 0, 0, "R9 setup");
    run_cmd(1, 1, 32'h3000_0000, 16, 2, 0, 0, 0, "R9 setup");
    run_cmd(5, 1, 32'h3000_0000, 16, 0, 0, 0, 0, "R9 own stream");
    run_cmd(5, 0, 32'h3000_0000, 16, 0, 0, 0, 0, "R9 opposite kept");
    do_serialize("R9");

    // R11 rotation replaces oldest
    for (int k = 0; k < 9; k++)
      run_cmd(0, 1, 32'h0600_0000 + 32'(k) * 32'h1000, 12, 0, 0, 0, 0, "R11 fill");
    run_cmd(2, 0, 32'h0600_0000, 12, 0, 0, 0, 0, "R11 oldest evicted");
    run_cmd(2, 0, 32'h0600_1000, 12, 0, 0, 0, 0, "R11 second kept");
    run_cmd(2, 0, 32'h0600_0000, 16, 0, 0, 0, 0, "R11 rest");

    // R12 slot replacement
    run_cmd(1, 0, 32'h0700_0000, 12, 3, 0, 0, 0, "R12 first");
    run_cmd(1, 0, 32'h0710_0000, 12, 3, 0, 0, 0, "R12 replace");
    run_cmd(5, 0, 32'h0700_0000, 12, 0, 0, 0, 0, "R12 old gone");
    run_cmd(5, 0, 32'h0710_0000, 12, 0, 0, 0, 0, "R12 new present");

    // R2 command held during busy is ignored; reserved opcodes
    run_cmd(0, 0, 32'h0800_0000, 12, 0, 0, 0, 1, "R2 ghost");
    run_cmd(2, 0, GHOST, 12, 0, 0, 0, 0, "R2 ghost not executed");
    run_cmd(6, 0, 32'h0800_0000, 12, 0, 0, 0, 0, "R2 reserved 6");
    run_cmd(7, 1, 32'h0800_0000, 12, 0, 0, 0, 0, "R2 reserved 7");
    run_cmd(2, 0, 32'h0800_0000, 12, 0, 0, 0, 0, "R2 entry untouched");

    // R10 violation on the serialize edge
    run_cmd(1, 1, 32'h0900_0000, 16, 0, 0, 0, 0, "R10 setup");
    run_cmd(0, 1, 32'h0900_1000, 12, 0, 0, 1, 0, "R10 same edge");
    do_serialize("R10 after same edge");

    // Sweep
    seed = 32'h1234_5678;
    for (int n = 0; n < 1500; n++) begin
      int op;
      int ps;
      int d;
      int slot;
      bit rem;
      bit ser;
      logic [31:0] base;
      seed = seed * 1103515245 + 12345;
      op   = int'((seed >> 16) % 8);
      d    = int'((seed >> 20) & 1);
      rem  = seed[25];
      slot = int'((seed >> 26) & 3);
      ser  = ((seed >> 8) % 11) == 0;
      case ((seed >> 12) % 5)
        0: ps = 12;
        1: ps = 16;
        2: ps = 20;
        3: ps = 24;
        default: ps = 28;
      endcase
      seed = seed * 1103515245 + 12345;
      base = seed & 32'h03FF_FFFF;
      base = base & ~((32'd1 << ps) - 1);
      if (ps == 28 && seed[3]) ps = 22;
      run_cmd(op, d, base, ps, slot, rem, ser, 0, op_tag(op, rem));
      if (n % 5 == 4) do_serialize("R10 sweep");
    end

    summary();
    $finish;
  end

endmodule